// File: doc/BRIEF.md
# Small-Page NAND Command Sequencer

This block takes one request at a time and plays it out as command and address cycles on the control and data lines of a single small-page NAND flash device. A request carries an opcode, an optional column, an optional page number, a flag for devices above 32 MiB and a flag for a 16-bit data bus. The sequencer expands it into a short list of latch cycles. Each cycle raises either the command latch or the address latch and strobes write-enable low and high again. After the last cycle it waits for the device as the opcode requires, then reports completion with a one-cycle done pulse that carries a timeout flag.

Three things set it apart from a plain byte pusher. A program-setup request is preceded by a pointer command, picked from the column offset. The third page-address cycle is sent only for large devices. Page reads keep chip enable low through the device's busy period, and the ready poll after a read has a bounded number of attempts. Data transfers, error correction and chip-select decoding belong to other blocks.

Top module: `nand_cmd_seq`

## Requirements
- R1: For opcode 0x80 (program setup) a pointer command is sent before it. The pointer is 0x50 with the column reduced by PAGE_BYTES when the column is at least PAGE_BYTES. It is 0x00 when the column is below 256 or absent. Otherwise it is 0x01, with the column reduced by 256.
- R2: Command cycles have cle=1, ale=0. Address cycles have cle=0, ale=1. When neither a column nor a page is present, no address cycle is sent. cle and ale are never high together.
- R3: The address cycles are sent in this order: column byte (if present), page bits 7:0, page bits 15:8, then page bits 19:16 in the low nibble with a zero upper nibble. The last of these is sent only when the large-device flag is set.
- R4: With the wide-bus flag set, the column byte is the adjusted column shifted right by one. The exceptions are opcodes 0x90 and 0xEC, which always take an unshifted column.
- R5: Each command or address byte is latched on the rising edge of nand_we_no. It appears on nand_dq_o[7:0] with nand_dq_o[15:8]=0, and the data and latch lines stay stable while nand_we_no is low.
- R6: Opcodes 0x10, 0x60, 0xD0, 0x80 and 0x70 complete right after their last bus cycle, without looking at nand_rb_i. They complete fewer than TWB_CYC cycles after the last write-enable rise, with timeout clear.
- R7: For every other opcode, nand_rb_i (1 = ready) is not sampled until TWB_CYC cycles after the last write-enable rise.
- R8: A read (0x00, 0x01, 0x50) with a page address samples ready at most POLL_MAX+1 times, with POLL_CYC idle cycles between samples. If ready is never seen, done comes with timeout_o=1.
- R9: nand_ce_no is low for the whole command/address phase. For a read with a page address it stays low until the cycle before done. For other waiting requests it is high while waiting.
- R10: Reset (0xFF), any read without a page address and any other waiting opcode wait for ready with no limit, and end with timeout clear.
- R11: req_ready_o is high only when idle. A request is taken on req_valid_i && req_ready_o, and no further request is taken until done_o has pulsed for exactly one cycle.
- R12: When idle (and after reset) nand_ce_no=1, nand_cle_o=0, nand_ale_o=0, nand_we_no=1 and nand_dq_oe_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| req_opcode_i | input | 8 | Command opcode |
| req_col_vld_i | input | 1 | Column address present |
| req_col_i | input | COL_W | Column address |
| req_page_vld_i | input | 1 | Page address present |
| req_page_i | input | 20 | Page address |
| req_large_i | input | 1 | Device larger than 32 MiB |
| req_wide_i | input | 1 | 16-bit data bus |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Ready not seen within the read poll limit, valid with done_o |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write enable, active low |
| nand_dq_o | output | 16 | Data bus output |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_rb_i | input | 1 | Ready/busy, 1 = ready |

## Verification
Two situations are hard to reach from the ports. One is a read whose ready line never rises, which must end by the poll limit with a timeout rather than hang. The other is a reset whose busy time runs well past that limit, which must still finish without a timeout. The bench holds the ready line low through whole requests and releases it on a timer in a parallel process, sometimes before and sometimes long after the bounded window. It also records the level of chip enable in the last waiting cycle. The column arithmetic corners are reached by program-setup requests whose columns fall in the spare area, in the upper half page and on a wide bus.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int SLOT_N = 6;
  localparam int PAGE_W = 20;

  localparam logic [7:0] OP_RD_LO    = 8'h00;
  localparam logic [7:0] OP_RD_HI    = 8'h01;
  localparam logic [7:0] OP_RD_SPARE = 8'h50;
  localparam logic [7:0] OP_LOAD     = 8'h80;
  localparam logic [7:0] OP_PROG     = 8'h10;
  localparam logic [7:0] OP_ERASE_A  = 8'h60;
  localparam logic [7:0] OP_ERASE_B  = 8'hD0;
  localparam logic [7:0] OP_STAT     = 8'h70;
  localparam logic [7:0] OP_ID       = 8'h90;
  localparam logic [7:0] OP_PARAM    = 8'hEC;

  typedef struct packed {
    logic       cle;
    logic       ale;
    logic [7:0] dat;
  } slot_t;

  typedef enum logic [1:0] {WAIT_NONE, WAIT_BOUNDED, WAIT_OPEN} wait_e;
endpackage

// File: rtl/nand_seq_plan.sv
module nand_seq_plan
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int COL_W      = 10,
  localparam int CNT_W     = $clog2(SLOT_N + 1)
) (
  input  logic [7:0]            opcode_i,
  input  logic                  col_vld_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic                  page_vld_i,
  input  logic [PAGE_W-1:0]     page_i,
  input  logic                  large_i,
  input  logic                  wide_i,
  output slot_t [SLOT_N-1:0]    slots_o,
  output logic [CNT_W-1:0]      cnt_o,
  output wait_e                 wait_o
);
  logic             is_load, is_read, byte_addr, no_wait;
  logic [7:0]       ptr;
  logic [COL_W-1:0] col_sub;
  logic [7:0]       col_byte;

  assign is_load   = opcode_i == OP_LOAD;
  assign is_read   = opcode_i == OP_RD_LO || opcode_i == OP_RD_HI || opcode_i == OP_RD_SPARE;
  assign byte_addr = opcode_i == OP_ID || opcode_i == OP_PARAM;
  assign no_wait   = opcode_i == OP_PROG || opcode_i == OP_ERASE_A || opcode_i == OP_ERASE_B ||
                     opcode_i == OP_LOAD || opcode_i == OP_STAT;

  // pointer selection and column rebasing for program setup
  always_comb begin
    ptr     = OP_RD_LO;
    col_sub = col_i;
    if (is_load && col_vld_i) begin
      if (col_i >= COL_W'(PAGE_BYTES)) begin
        ptr     = OP_RD_SPARE;
        col_sub = col_i - COL_W'(PAGE_BYTES);
      end else if (col_i >= COL_W'(256)) begin
        ptr     = OP_RD_HI;
        col_sub = col_i - COL_W'(256);
      end
    end
    col_byte = 8'((wide_i && !byte_addr) ? (col_sub >> 1) : col_sub);
  end

  always_comb begin
    logic [CNT_W-1:0] n;
    slots_o = '0;
    n       = '0;
    if (is_load) begin
      slots_o[n] = '{cle: 1'b1, ale: 1'b0, dat: ptr};
      n = n + CNT_W'(1);
    end
    slots_o[n] = '{cle: 1'b1, ale: 1'b0, dat: opcode_i};
    n = n + CNT_W'(1);
    if (col_vld_i) begin
      slots_o[n] = '{cle: 1'b0, ale: 1'b1, dat: col_byte};
      n = n + CNT_W'(1);
    end
    if (page_vld_i) begin
      slots_o[n] = '{cle: 1'b0, ale: 1'b1, dat: page_i[7:0]};
      n = n + CNT_W'(1);
      slots_o[n] = '{cle: 1'b0, ale: 1'b1, dat: page_i[15:8]};
      n = n + CNT_W'(1);
      if (large_i) begin
        slots_o[n] = '{cle: 1'b0, ale: 1'b1, dat: {4'h0, page_i[19:16]}};
        n = n + CNT_W'(1);
      end
    end
    cnt_o = n;
  end

  always_comb begin
    if (no_wait)                   wait_o = WAIT_NONE;
    else if (is_read && page_vld_i) wait_o = WAIT_BOUNDED;
    else                           wait_o = WAIT_OPEN;
  end
endmodule

// File: rtl/nand_we_pulse.sv
module nand_we_pulse #(
  parameter int WE_LO = 2,
  parameter int WE_HI = 2,
  localparam int CW   = $clog2(WE_LO + WE_HI + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o,
  output logic we_no,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  assign we_no  = !(busy_o && cnt_q < CW'(WE_LO));
  assign last_o = busy_o && cnt_q == CW'(WE_LO + WE_HI - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (go_i) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (last_o) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/nand_rb_wait.sv
module nand_rb_wait
  import nand_seq_pkg::*;
#(
  parameter int TWB_CYC  = 5,
  parameter int POLL_CYC = 50,
  parameter int POLL_MAX = 30,
  localparam int CW      = $clog2((TWB_CYC > POLL_CYC ? TWB_CYC : POLL_CYC) + 1),
  localparam int TW      = $clog2(POLL_MAX + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  go_i,
  input  wait_e mode_i,
  input  logic  rb_i,
  output logic  fin_o,
  output logic  tmo_o
);
  typedef enum logic [1:0] {W_IDLE, W_TWB, W_SAMPLE, W_GAP} w_e;
  w_e            st_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tries_q;
  logic          bounded, spent;

  assign bounded = mode_i == WAIT_BOUNDED;
  assign spent   = bounded && tries_q == TW'(POLL_MAX);
  assign fin_o   = st_q == W_SAMPLE && (rb_i || spent);
  assign tmo_o   = fin_o && !rb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= W_IDLE;
      cnt_q   <= '0;
      tries_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (go_i) begin
          st_q    <= W_TWB;
          cnt_q   <= CW'(TWB_CYC - 1);
          tries_q <= '0;
        end
        W_TWB: begin
          if (cnt_q == '0) st_q <= W_SAMPLE;
          else             cnt_q <= cnt_q - CW'(1);
        end
        W_SAMPLE: begin
          if (fin_o) st_q <= W_IDLE;
          else if (bounded) begin
            st_q    <= W_GAP;
            cnt_q   <= CW'(POLL_CYC - 1);
            tries_q <= tries_q + TW'(1);
          end
        end
        W_GAP: begin
          if (cnt_q == '0) st_q <= W_SAMPLE;
          else             cnt_q <= cnt_q - CW'(1);
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int COL_W      = 10,
  parameter int WE_LO      = 2,
  parameter int WE_HI      = 2,
  parameter int TWB_CYC    = 5,
  parameter int POLL_CYC   = 50,
  parameter int POLL_MAX   = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [7:0]        req_opcode_i,
  input  logic              req_col_vld_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_page_vld_i,
  input  logic [19:0]       req_page_i,
  input  logic              req_large_i,
  input  logic              req_wide_i,
  output logic              done_o,
  output logic              timeout_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic [15:0]       nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic              nand_rb_i
);
  localparam int CNT_W = $clog2(SLOT_N + 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_e;

  st_e                st_q;
  slot_t [SLOT_N-1:0] slots_d, slots_q;
  logic [CNT_W-1:0]   cnt_d, cnt_q, idx_q;
  wait_e              wk_d, wk_q;
  logic               tmo_q;
  logic               bc_go, bc_busy, bc_we_n, bc_last;
  logic               rw_go, rw_fin, rw_tmo;
  logic               issuing, last_slot;
  slot_t              cur;

  nand_seq_plan #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_plan (
    .opcode_i  (req_opcode_i),
    .col_vld_i (req_col_vld_i),
    .col_i     (req_col_i),
    .page_vld_i(req_page_vld_i),
    .page_i    (req_page_i),
    .large_i   (req_large_i),
    .wide_i    (req_wide_i),
    .slots_o   (slots_d),
    .cnt_o     (cnt_d),
    .wait_o    (wk_d)
  );

  nand_we_pulse #(.WE_LO(WE_LO), .WE_HI(WE_HI)) u_we (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (bc_go),
    .busy_o(bc_busy),
    .we_no (bc_we_n),
    .last_o(bc_last)
  );

  nand_rb_wait #(.TWB_CYC(TWB_CYC), .POLL_CYC(POLL_CYC), .POLL_MAX(POLL_MAX)) u_rb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (rw_go),
    .mode_i(wk_q),
    .rb_i  (nand_rb_i),
    .fin_o (rw_fin),
    .tmo_o (rw_tmo)
  );

  assign issuing   = st_q == S_ISSUE;
  assign cur       = slots_q[idx_q];
  assign last_slot = idx_q == cnt_q - CNT_W'(1);
  assign bc_go     = issuing && !bc_busy;
  assign rw_go     = issuing && bc_last && last_slot && wk_q != WAIT_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      slots_q <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      wk_q    <= WAIT_NONE;
      tmo_q   <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          slots_q <= slots_d;
          cnt_q   <= cnt_d;
          wk_q    <= wk_d;
          idx_q   <= '0;
          tmo_q   <= 1'b0;
          st_q    <= S_ISSUE;
        end
        S_ISSUE: if (bc_last) begin
          if (last_slot) st_q <= (wk_q == WAIT_NONE) ? S_DONE : S_WAIT;
          else           idx_q <= idx_q + CNT_W'(1);
        end
        S_WAIT: if (rw_fin) begin
          tmo_q <= rw_tmo;
          st_q  <= S_DONE;
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o  = st_q == S_IDLE;
  assign done_o       = st_q == S_DONE;
  assign timeout_o    = done_o && tmo_q;
  // chip enable held through a page read's busy time
  assign nand_ce_no   = !(issuing || (st_q == S_WAIT && wk_q == WAIT_BOUNDED));
  assign nand_cle_o   = issuing && cur.cle;
  assign nand_ale_o   = issuing && cur.ale;
  assign nand_we_no   = bc_we_n;
  assign nand_dq_o    = issuing ? {8'h00, cur.dat} : 16'h0000;
  assign nand_dq_oe_o = issuing;
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        done_o,
  input logic        timeout_o,
  input logic        nand_ce_no,
  input logic        nand_cle_o,
  input logic        nand_ale_o,
  input logic        nand_we_no,
  input logic [15:0] nand_dq_o,
  input logic        nand_dq_oe_o
);
  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (nand_ce_no && !nand_cle_o && !nand_ale_o && nand_we_no && !nand_dq_oe_o));

  assert_latch_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  assert_strobe_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no && $past(!nand_we_no)) |-> ($stable(nand_dq_o) && $stable(nand_cle_o) && $stable(nand_ale_o)));

  assert_low_half_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> (nand_dq_oe_o && nand_dq_o[15:8] == 8'h00));

  assert_ce_on_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> !nand_ce_no);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));

  assert_accept_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_tmo_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (.*);

// File: tb/sim_nand_cmd_seq.sv
module sim_nand_cmd_seq;
  localparam int PAGE_BYTES = 512;
  localparam int COL_W      = 10;
  localparam int TWB_CYC    = 5;
  localparam int POLL_CYC   = 50;
  localparam int POLL_MAX   = 30;
  localparam int K_NONE = 0, K_BOUND = 1, K_OPEN = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_opcode = '0;
  logic req_col_vld = 1'b0, req_page_vld = 1'b0, req_large = 1'b0, req_wide = 1'b0;
  logic [COL_W-1:0] req_col = '0;
  logic [19:0] req_page = '0;
  logic done, tmo, ce_n, cle, ale, we_n, dq_oe;
  logic [15:0] dq;
  logic rb = 1'b1;

  always #10 clk = ~clk;

  nand_cmd_seq #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W), .WE_LO(2), .WE_HI(2),
                 .TWB_CYC(TWB_CYC), .POLL_CYC(POLL_CYC), .POLL_MAX(POLL_MAX)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_opcode_i(req_opcode), .req_col_vld_i(req_col_vld), .req_col_i(req_col),
    .req_page_vld_i(req_page_vld), .req_page_i(req_page), .req_large_i(req_large),
    .req_wide_i(req_wide), .done_o(done), .timeout_o(tmo), .nand_ce_no(ce_n),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n), .nand_dq_o(dq),
    .nand_dq_oe_o(dq_oe), .nand_rb_i(rb)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, done_cnt = 0, last_rise = 0;
  logic [9:0] byte_q[$];
  int kind_q[$];
  logic tmo_q[$];
  logic prev_we = 1'b1, prev_ce = 1'b1;
  string tag_q[$];
  bit ended = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: bus bytes and completions
  always @(negedge clk) begin
    if (rst_ni) begin
      if (!prev_we && we_n) begin
        last_rise = cyc;
        if (byte_q.size() == 0)
          check(0, "R2 unexpected bus byte", {cle, ale, dq[7:0]}, 0);
        else begin
          logic [9:0] e;
          e = byte_q.pop_front();
          check({cle, ale, dq[7:0]} == e, "R1/R2/R3/R4 bus byte", {cle, ale, dq[7:0]}, e);
          check(dq[15:8] == 8'h00, "R5 upper half zero", dq[15:8], 0);
        end
      end
      if (done) begin
        int k, d;
        logic et;
        string tg;
        done_cnt++;
        d = cyc - last_rise;
        if (kind_q.size() == 0) check(0, "R11 unexpected done", 1, 0);
        else begin
          k  = kind_q.pop_front();
          et = tmo_q.pop_front();
          tg = tag_q.pop_front();
          check(tmo == et, {tg, " timeout flag"}, tmo, et);
          check(byte_q.size() == 0, {tg, " all bytes sent (R3)"}, byte_q.size(), 0);
          if (k == K_NONE)
            check(d < TWB_CYC, "R6 immediate completion", d, TWB_CYC);
          else begin
            check(d >= TWB_CYC, "R7 tWB before ready sample", d, TWB_CYC);
            if (k == K_BOUND)
              check(prev_ce == 1'b0, "R9 ce held through read wait", prev_ce, 0);
            else
              check(prev_ce == 1'b1, "R9 ce released in open wait", prev_ce, 1);
            if (k == K_BOUND && et)
              check(d >= POLL_MAX * POLL_CYC, "R8 poll window length", d, POLL_MAX * POLL_CYC);
          end
        end
      end
    end
    prev_we = we_n;
    prev_ce = ce_n;
  end

  task automatic send(input logic [7:0] opc, input bit cv, input int col, input bit pv,
                      input int page, input bit lg, input bit wd, input int kind,
                      input bit exp_tmo, input string tg);
    int c;
    int d0;
    logic [7:0] ptr;
    logic [19:0] p;
    c = col;
    p = page[19:0];
    if (opc == 8'h80) begin
      if (!cv) ptr = 8'h00;
      else if (c >= PAGE_BYTES) begin ptr = 8'h50; c = c - PAGE_BYTES; end
      else if (c < 256) ptr = 8'h00;
      else begin ptr = 8'h01; c = c - 256; end
      byte_q.push_back({2'b10, ptr});
    end
    byte_q.push_back({2'b10, opc});
    if (cv) begin
      if (wd && opc != 8'h90 && opc != 8'hEC) c = c >> 1;
      byte_q.push_back({2'b01, c[7:0]});
    end
    if (pv) begin
      byte_q.push_back({2'b01, p[7:0]});
      byte_q.push_back({2'b01, p[15:8]});
      if (lg) byte_q.push_back({2'b01, 4'h0, p[19:16]});
    end
    kind_q.push_back(kind);
    tmo_q.push_back(exp_tmo);
    tag_q.push_back(tg);
    d0 = done_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid    = 1'b1;
    req_opcode   = opc;
    req_col_vld  = cv;
    req_col      = COL_W'(col);
    req_page_vld = pv;
    req_page     = p;
    req_large    = lg;
    req_wide     = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R11 busy after accept", req_ready, 0);
    while (done_cnt == d0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ce_n == 1'b1 && cle == 1'b0 && ale == 1'b0 && we_n == 1'b1 && dq_oe == 1'b0,
          "R12 reset state", {ce_n, cle, ale, we_n, dq_oe}, 5'b10010);
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R11 ready when idle", req_ready, 1);

    // R8/R9 read, ready returns inside the poll window
    fork
      send(8'h00, 1, 'h12, 1, 'h03456, 0, 0, K_BOUND, 0, "R8 read ok");
      begin rb = 1'b0; repeat (100) @(negedge clk); rb = 1'b1; end
    join
    // R8 read spare area, large device, never ready -> timeout
    rb = 1'b0;
    send(8'h50, 1, 'h05, 1, 'hABCDE, 1, 0, K_BOUND, 1, "R8 read timeout");
    // R1 program setup variants; R6 no wait while busy
    send(8'h80, 1, 600, 1, 'h00102, 0, 0, K_NONE, 0, "R1 spare pointer");
    send(8'h80, 1, 'h40, 1, 'h00203, 0, 0, K_NONE, 0, "R1 low pointer");
    send(8'h80, 1, 300, 1, 'h00304, 0, 0, K_NONE, 0, "R1 high pointer");
    send(8'h80, 1, 300, 1, 'h00405, 0, 1, K_NONE, 0, "R4 wide program setup");
    send(8'h10, 0, 0, 0, 0, 0, 0, K_NONE, 0, "R6 program");
    send(8'h60, 0, 0, 1, 'h7F0A1, 1, 0, K_NONE, 0, "R3 erase large");
    send(8'hD0, 0, 0, 0, 0, 0, 0, K_NONE, 0, "R6 erase confirm");
    send(8'h70, 0, 0, 0, 0, 0, 0, K_NONE, 0, "R6 status");
    rb = 1'b1;
    // R4 wide bus read and byte-addressed opcode
    send(8'h00, 1, 'h64, 1, 'h00011, 0, 1, K_BOUND, 0, "R4 wide read");
    send(8'h90, 1, 'h20, 0, 0, 0, 1, K_OPEN, 0, "R4 byte address opcode");
    // R10 reset waits past the read window without timing out
    fork
      send(8'hFF, 0, 0, 0, 0, 0, 0, K_OPEN, 0, "R10 reset long busy");
      begin rb = 1'b0; repeat (2500) @(negedge clk); rb = 1'b1; end
    join
    // R10 read without page address is an open wait
    fork
      send(8'h01, 1, 'h33, 0, 0, 0, 0, K_OPEN, 0, "R10 read column only");
      begin rb = 1'b0; repeat (60) @(negedge clk); rb = 1'b1; end
    join
    @(negedge clk);
    check(ce_n == 1'b1 && we_n == 1'b1 && dq_oe == 1'b0, "R12 idle after run",
          {ce_n, we_n, dq_oe}, 3'b110);
    finish_up();
  end
endmodule